// File: doc/BRIEF.md
# Halfword-to-Word Register Access Bridge

This bridge connects a host bus that moves 16 bits per access to a peripheral whose registers are 32 bits wide. The host moves a full register in two halfword accesses, and the half is chosen by host address bit 1. The bridge joins the two writes into one 32-bit peripheral write, and it splits one 32-bit peripheral read into two host reads. Both halves of a transfer therefore belong to the same register value.

For a write, the low half is parked in a holding register. The high-half write then issues the single peripheral write, using the new upper data and the parked lower data. For a read, the low-half read fetches the whole word from the peripheral. It returns the lower 16 bits and keeps the upper 16 bits in a snapshot register. The high-half read that follows is served from that snapshot and does not touch the peripheral again.

Byte-wide accesses cannot be served. Such an access is rejected with a one-cycle error pulse, and the peripheral and the bridge state are left alone. Host strobes last one cycle. Peripheral strobes are issued in the same cycle as the host strobe. Host read data and the error flag are registered and appear in the cycle after the host strobe.

Top module: `hw_word_bridge`

## Requirements
- R1: Host address bit 1 selects the half, with 0 for bits 15:0 and 1 for bits 31:16. The peripheral word address `per_addr` always equals `host_addr[ADDR_W-1:2]`.
- R2: A halfword write with bit 1 = 0 stores `host_wdata` in the holding register and does not assert `per_wr`.
- R3: A halfword write with bit 1 = 1 asserts `per_wr` for exactly that cycle. `per_wdata` then carries `host_wdata` in bits 31:16 and the holding register in bits 15:0.
- R4: A halfword read with bit 1 = 0 asserts `per_rd` in that cycle. On the next cycle, `host_rdata` equals the sampled `per_rdata[15:0]`, and bits 31:16 of that word are stored in the snapshot register.
- R5: A halfword read with bit 1 = 1 does not assert `per_rd`. On the next cycle, `host_rdata` equals the snapshot register.
- R6: An access with `host_byte` = 1 asserts neither `per_rd` nor `per_wr`. `host_err` is 1 for exactly the following cycle, and a byte read returns 0 on `host_rdata`.
- R7: A byte access changes neither the holding register nor the snapshot register. This is seen through a later high-half write or high-half read.
- R8: After reset, `host_rdata` is 0 and `host_err` is 0. The holding and snapshot registers are 0, so a high-half write with no earlier low-half write sends 0 in bits 15:0, and a first high-half read returns 0.
- R9: When `host_rd` and `host_wr` are asserted together, only the write is performed. The read is ignored, and `host_rdata` keeps its value.
- R10: `host_rdata` keeps its value in every cycle that follows a cycle with no accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W-1 | Host byte address bits ADDR_W-1:1; bit 1 selects the half |
| host_byte | input | 1 | 1 marks a byte-wide access |
| host_rd | input | 1 | Single-cycle read strobe |
| host_wr | input | 1 | Single-cycle write strobe |
| host_wdata | input | HALF_W | Halfword write data |
| host_rdata | output | HALF_W | Registered halfword read data, valid the cycle after a read |
| host_err | output | 1 | One-cycle pulse after a rejected byte access |
| per_addr | output | ADDR_W-2 | Peripheral word address |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | 2*HALF_W | Peripheral write data |
| per_rdata | input | 2*HALF_W | Peripheral read data, valid in the cycle `per_rd` is high |

## Verification
The bench checks that the parked low half survives a byte write and an intervening read before the high write. A design that let either of these disturb the holding register would send stale or corrupted bits 15:0. It checks that the high-half read returns the snapshot even after the peripheral word has been rewritten. A design that fetched the word again would return the new upper bits and tear the value. It also covers the first high write and the first high read after reset, where wrong reset values would show up in the data. It drives simultaneous read and write strobes, where a design that let the read proceed would change `host_rdata` or issue a stray `per_rd`.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  typedef enum logic [2:0] {
    HWB_IDLE   = 3'd0,
    HWB_WR_LO  = 3'd1,
    HWB_WR_HI  = 3'd2,
    HWB_RD_LO  = 3'd3,
    HWB_RD_HI  = 3'd4,
    HWB_BAD_RD = 3'd5,
    HWB_BAD_WR = 3'd6
  } hwb_op_e;
endpackage

// File: rtl/hwb_classify.sv
module hwb_classify
  import hwb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    upper,
  input  logic    is_byte,
  input  logic    rd,
  input  logic    wr,
  output hwb_op_e op,
  output logic    err_q
);
  always_comb begin
    op = HWB_IDLE;
    if (wr)
      op = is_byte ? HWB_BAD_WR : (upper ? HWB_WR_HI : HWB_WR_LO);
    else if (rd)
      op = is_byte ? HWB_BAD_RD : (upper ? HWB_RD_HI : HWB_RD_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (op == HWB_BAD_RD) || (op == HWB_BAD_WR);
  end

  // R6: the error flag follows every byte strobe and nothing else
  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    ((rd || wr) && is_byte) |=> err_q);
  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !((rd || wr) && is_byte) |=> !err_q);
endmodule

// File: rtl/hwb_write_join.sv
module hwb_write_join
  import hwb_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  hwb_op_e           op,
  input  logic [HALF_W-1:0] wdata,
  output logic              wr_stb,
  output logic [2*HALF_W-1:0] wr_word
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] park_q;

  always_ff @(posedge clk) begin
    if (rst)                   park_q <= '0;
    else if (op == HWB_WR_LO)  park_q <= wdata;
  end

  assign wr_stb  = (op == HWB_WR_HI);
  assign wr_word = {wdata, park_q};

  // R2: a low-half write lands in the holding register
  assert_park_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (op == HWB_WR_LO) |=> (park_q == $past(wdata)));
  // R7: byte writes leave the holding register alone
  assert_park_byte_R7: assert property (@(posedge clk) disable iff (rst)
    (op == HWB_BAD_WR || op == HWB_BAD_RD) |=> $stable(park_q));
  // R3: the upper half of the word is always the current host data
  assert_word_upper_R3: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (wr_word[WORD_W-1:HALF_W] == wdata));
endmodule

// File: rtl/hwb_read_split.sv
module hwb_read_split
  import hwb_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  hwb_op_e           op,
  input  logic [2*HALF_W-1:0] rd_word,
  output logic              rd_stb,
  output logic [HALF_W-1:0] rdata_q
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (op)
        HWB_RD_LO: begin
          rdata_q <= rd_word[HALF_W-1:0];
          snap_q  <= rd_word[WORD_W-1:HALF_W];
        end
        HWB_RD_HI:  rdata_q <= snap_q;
        HWB_BAD_RD: rdata_q <= '0;
        default: ;
      endcase
    end
  end

  assign rd_stb = (op == HWB_RD_LO);

  // R4: low-half read returns the low bits and keeps the high bits
  assert_lo_read_R4: assert property (@(posedge clk) disable iff (rst)
    (op == HWB_RD_LO) |=> (rdata_q == $past(rd_word[HALF_W-1:0]))
                          && (snap_q == $past(rd_word[WORD_W-1:HALF_W])));
  // R7: byte accesses leave the snapshot alone
  assert_snap_byte_R7: assert property (@(posedge clk) disable iff (rst)
    (op == HWB_BAD_WR || op == HWB_BAD_RD) |=> $stable(snap_q));
  // R6: byte reads return zero
  assert_byte_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (op == HWB_BAD_RD) |=> (rdata_q == '0));
endmodule

// File: rtl/hw_word_bridge.sv
module hw_word_bridge
  import hwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:1]   host_addr,
  input  logic                host_byte,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic [HALF_W-1:0]   host_wdata,
  output logic [HALF_W-1:0]   host_rdata,
  output logic                host_err,
  output logic [ADDR_W-1:2]   per_addr,
  output logic                per_rd,
  output logic                per_wr,
  output logic [2*HALF_W-1:0] per_wdata,
  input  logic [2*HALF_W-1:0] per_rdata
);
  hwb_op_e op;

  hwb_classify u_classify (
    .clk     (clk),
    .rst     (rst),
    .upper   (host_addr[1]),
    .is_byte (host_byte),
    .rd      (host_rd),
    .wr      (host_wr),
    .op      (op),
    .err_q   (host_err)
  );

  hwb_write_join #(.HALF_W(HALF_W)) u_write (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .wdata   (host_wdata),
    .wr_stb  (per_wr),
    .wr_word (per_wdata)
  );

  hwb_read_split #(.HALF_W(HALF_W)) u_read (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .rd_word (per_rdata),
    .rd_stb  (per_rd),
    .rdata_q (host_rdata)
  );

  assign per_addr = host_addr[ADDR_W-1:2];

  // R2: a low-half write never reaches the peripheral
  assert_lo_write_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_byte && !host_addr[1]) |-> !per_wr);
  // R5: a high-half read never reaches the peripheral
  assert_hi_read_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr && !host_byte && host_addr[1]) |-> !per_rd);
  // R6: byte accesses issue no peripheral strobe
  assert_byte_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    host_byte |-> !(per_rd || per_wr));
  // R9 / R10: no accepted read means read data holds
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!host_rd || host_wr) |=> $stable(host_rdata));
  // R3: peripheral write strobe is one cycle per host strobe
  assert_wr_single_R3: assert property (@(posedge clk) disable iff (rst)
    (per_wr && !(host_wr && $past(host_wr))) |=> !per_wr || host_wr);
endmodule

// File: tb/hw_word_bridge_tb_top.sv
module hw_word_bridge_tb_top;
  localparam int ADDR_W = 8;
  localparam int HALF_W = 16;
  localparam int NWORDS = 1 << (ADDR_W - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:1] host_addr = '0;
  logic host_byte = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [HALF_W-1:0] host_wdata = '0;
  logic [HALF_W-1:0] host_rdata;
  logic host_err;
  logic [ADDR_W-1:2] per_addr;
  logic per_rd, per_wr;
  logic [2*HALF_W-1:0] per_wdata;
  logic [2*HALF_W-1:0] per_rdata;

  always #10 clk = ~clk;

  hw_word_bridge #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_byte(host_byte),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_err(host_err), .per_addr(per_addr),
    .per_rd(per_rd), .per_wr(per_wr), .per_wdata(per_wdata),
    .per_rdata(per_rdata)
  );

  // behavioural peripheral and reference state
  logic [31:0] mem [NWORDS];
  assign per_rdata = mem[per_addr];
  int m_hold, m_snap, m_rdata, m_err;
  string prev_tag = "R8";
  string force_tag = "";
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(bit rd, bit wr, bit b, int a, int wd);
    bit a1, bad, wr_e, rd_e;
    string tag;
    int w;
    @(negedge clk);
    chk(prev_tag, int'(host_rdata), m_rdata);
    chk(m_err ? "R6" : prev_tag, int'(host_err), m_err);
    host_addr = a[ADDR_W-1:1]; host_rd = rd; host_wr = wr;
    host_byte = b; host_wdata = wd[HALF_W-1:0];
    a1 = a[1]; bad = b && (rd || wr);
    wr_e = wr && !b; rd_e = rd && !wr && !b;
    w = (a >> 2) & (NWORDS - 1);
    if (bad) tag = "R6";
    else if (rd && wr) tag = "R9";
    else if (wr) tag = a1 ? "R3" : "R2";
    else if (rd) tag = a1 ? "R5" : "R4";
    else tag = "R10";
    if (force_tag != "") tag = force_tag;
    #1;
    chk("R1", int'(per_addr), w);
    chk(tag, int'(per_wr), int'(wr_e && a1));
    chk(tag, int'(per_rd), int'(rd_e && !a1));
    if (wr_e && a1) chk(tag, int'(per_wdata), {wd[15:0], m_hold[15:0]});
    @(posedge clk); #1;
    if (wr_e && !a1) m_hold = wd & 16'hffff;
    if (wr_e && a1) mem[w] = {wd[15:0], m_hold[15:0]};
    if (rd_e && !a1) begin
      m_rdata = int'(mem[w][15:0]); m_snap = int'(mem[w][31:16]);
    end
    if (rd_e && a1) m_rdata = m_snap;
    if (bad && rd && !wr) m_rdata = 0;
    m_err = int'(bad);
    prev_tag = tag;
    host_rd = 0; host_wr = 0;
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) mem[i] = 32'h9E37_79B9 * (i + 1) ^ 32'h5A5A_0F0F;
    m_hold = 0; m_snap = 0; m_rdata = 0; m_err = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", int'(host_rdata), 0);
    chk("R8", int'(host_err), 0);
    // R8: first high write and first high read see reset zeros
    force_tag = "R8";
    step(0, 1, 0, 8'h06, 16'hBEEF);
    step(1, 0, 0, 8'h12, 0);
    force_tag = "";
    // R4/R5: paired read keeps the word consistent after rewrite
    step(1, 0, 0, 8'h20, 0);
    step(0, 1, 0, 8'h00, 16'h1111);
    step(0, 1, 0, 8'h22, 16'h2222);
    step(1, 0, 0, 8'h22, 0);
    step(1, 0, 0, 8'h20, 0);
    step(1, 0, 0, 8'h22, 0);
    // R7: byte accesses between halves disturb nothing
    step(0, 1, 0, 8'h30, 16'hA5A5);
    step(0, 1, 1, 8'h30, 16'hFFFF);
    step(1, 0, 1, 8'h30, 0);
    force_tag = "R7";
    step(0, 1, 0, 8'h32, 16'h5A5A);
    force_tag = "";
    step(1, 0, 0, 8'h30, 0);
    step(1, 0, 1, 8'h32, 0);
    force_tag = "R7";
    step(1, 0, 0, 8'h32, 0);
    force_tag = "";
    // R9: both strobes together
    step(1, 1, 0, 8'h40, 16'h7777);
    step(1, 1, 0, 8'h42, 16'h8888);
    step(1, 0, 0, 8'h42, 0);
    // R10: idle cycles hold read data
    step(0, 0, 0, 8'h00, 0);
    step(0, 0, 1, 8'h00, 0);
    for (int n = 0; n < 3000; n++)
      step($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 7) == 0),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)));
    @(negedge clk);
    chk(prev_tag, int'(host_rdata), m_rdata);
    chk(m_err ? "R6" : prev_tag, int'(host_err), m_err);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule